// File: doc/BRIEF.md
# Address Bus Hold and Backoff Controller

This block sits in a bus master between its queue of pending bus cycles and the pad drivers. It decides when a new cycle may be announced on the bus. It drives an active-low address strobe and a duplicate of it, the cycle address and its even parity bit, and the output-enable controls that float the address, the parity and the other floatable pins. It tracks, in issue order, every cycle that has been strobed but has not yet finished its data phase.

Two external requests take the bus away from the master. An address-only hold floats the address and parity pins in the following clock. During that hold, data phases of cycles already on the bus keep completing. A backoff floats every floatable pin in the following clock and aborts all cycles that have not completed. Once the backoff is released, the aborted cycles are strobed again from their first transfer, oldest first, before any new request. A replay flag and a slot pointer mark each of these re-issues.

Requests are offered with a valid/address pair. A request is taken on the clock edge where both valid and the combinational ready output are high. Completion of the oldest issued cycle is signalled with a one-clock done input. DEPTH must be a power of two and at least 2.

Top module: `bushold_ctl`

## Requirements
- R1: After reset, both strobes are high (idle), the address, parity and bus output enables are high, the outstanding count is 0, and ready is high when no hold or backoff is requested.
- R2: When hold_i is sampled high at a clock edge, addr_oe_o and par_oe_o are low in the following clock. When hold_i is low and boff_n_i is high at an edge, they are high in the following clock. bus_oe_o is not affected by hold_i.
- R3: While hold_i is high and boff_n_i is high, done_i still retires the oldest issued cycle, and out_cnt_o drops by one in the next clock.
- R4: No strobe is driven in the clock after an edge where hold_i is high or boff_n_i is low, and req_ready_o is low while either is requested.
- R5: When boff_n_i is sampled low, bus_oe_o, addr_oe_o and par_oe_o are low in the following clock. Every issued cycle that has not completed becomes unissued, and done_i is ignored while boff_n_i is low.
- R6: After a backoff ends, each aborted cycle is strobed again with its original address, in original issue order, with replay_o high and replay_ptr_o giving its slot. req_ready_o stays low until all of them are re-issued.
- R7: ads_dup_n_o equals ads_n_o in every clock.
- R8: Each accepted request or replay produces one low clock of ads_n_o in the clock after the accepting edge, with addr_o equal to the cycle address. par_o always makes the count of ones in {addr_o, par_o} even. A new request takes slot (oldest slot + outstanding count) mod DEPTH, and slots are filled from 0 after reset.
- R9: When hold_i and the backoff request are both active, the backoff behaviour of R5 applies in full.
- R10: out_cnt_o never exceeds DEPTH, and req_ready_o is low while DEPTH cycles are outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | A new bus cycle is requested |
| req_addr_i | input | ADDR_W | Address of the requested cycle |
| req_ready_o | output | 1 | Request is taken at this edge if valid |
| hold_i | input | 1 | Address-only hold request, active high |
| boff_n_i | input | 1 | Backoff request, active low |
| done_i | input | 1 | Oldest issued cycle has finished its data phase |
| ads_n_o | output | 1 | Address strobe, active low |
| ads_dup_n_o | output | 1 | Duplicate address strobe, active low |
| addr_o | output | ADDR_W | Address of the current or last strobed cycle |
| par_o | output | 1 | Even parity bit over addr_o |
| addr_oe_o | output | 1 | Drive enable for the address pins |
| par_oe_o | output | 1 | Drive enable for the parity pin |
| bus_oe_o | output | 1 | Drive enable for the other floatable pins |
| replay_o | output | 1 | Current strobe re-issues an aborted cycle |
| replay_ptr_o | output | $clog2(DEPTH) | Slot of the cycle being strobed |
| out_cnt_o | output | $clog2(DEPTH+1) | Cycles held: issued or awaiting replay |

## Verification
The assertions check the per-clock rules on every cycle: floating one clock after hold or backoff, no strobe under either request, strobe and duplicate equal, parity always even, and the count bounded. Replay order, the addresses carried by replays, retirement during an address hold, and ready staying low until all replays are out depend on history. Only the bench's reference model can show these, through scenarios that stack several cycles and then back off with both requests active.

// File: rtl/bhc_pkg.sv
package bhc_pkg;
    typedef enum logic [1:0] {
        ISS_NONE   = 2'd0,
        ISS_NEW    = 2'd1,
        ISS_REPLAY = 2'd2
    } iss_kind_e;
endpackage

// File: rtl/bhc_parity.sv
module bhc_parity #(
    parameter int W = 32
) (
    input  logic [W-1:0] data_i,
    output logic         par_o
);
    // even parity: total ones across data and parity bit is even
    assign par_o = ^data_i;
endmodule

// File: rtl/bhc_slot_store.sv
module bhc_slot_store #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [IDX_W-1:0]  rd_idx_i,
    output logic [ADDR_W-1:0] rd_addr_o
);
    logic [ADDR_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g] <= '0;
            end else if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                slot_q[g] <= wr_addr_i;
            end
        end
    end

    assign rd_addr_o = slot_q[rd_idx_i];
endmodule

// File: rtl/bushold_ctl.sv
module bushold_ctl #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    output logic              req_ready_o,
    input  logic              hold_i,
    input  logic              boff_n_i,
    input  logic              done_i,
    output logic              ads_n_o,
    output logic              ads_dup_n_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              par_o,
    output logic              addr_oe_o,
    output logic              par_oe_o,
    output logic              bus_oe_o,
    output logic              replay_o,
    output logic [IDX_W-1:0]  replay_ptr_o,
    output logic [CNT_W-1:0]  out_cnt_o
);
    import bhc_pkg::*;

    typedef struct packed {
        logic [IDX_W-1:0]  head;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  icnt;
        logic              ads_n;
        logic              ads_dup_n;
        logic [ADDR_W-1:0] addr;
        logic              replay;
        logic [IDX_W-1:0]  rptr;
        logic              addr_oe;
        logic              par_oe;
        logic              bus_oe;
    } st_t;

    st_t st_q, st_d;

    logic              hold_any;
    logic              repl_pend;
    logic              full;
    logic              ready;
    logic              retire;
    iss_kind_e         kind;
    logic [IDX_W-1:0]  tail_idx;
    logic [IDX_W-1:0]  iss_idx;
    logic [ADDR_W-1:0] iss_addr;
    logic              wr_en;

    assign hold_any  = hold_i || !boff_n_i;
    assign repl_pend = (st_q.icnt != st_q.cnt);
    assign full      = (st_q.cnt == CNT_W'(DEPTH));
    assign ready     = !hold_any && !repl_pend && !full;
    assign tail_idx  = st_q.head + IDX_W'(st_q.cnt);
    assign iss_idx   = st_q.head + IDX_W'(st_q.icnt);
    assign wr_en     = (kind == ISS_NEW);

    bhc_slot_store #(
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (tail_idx),
        .wr_addr_i (req_addr_i),
        .rd_idx_i  (iss_idx),
        .rd_addr_o (iss_addr)
    );

    bhc_parity #(
        .W (ADDR_W)
    ) u_par (
        .data_i (st_q.addr),
        .par_o  (par_o)
    );

    always_comb begin
        st_d           = st_q;
        st_d.ads_n     = 1'b1;
        st_d.ads_dup_n = 1'b1;
        st_d.replay    = 1'b0;
        st_d.addr_oe   = !hold_any;
        st_d.par_oe    = !hold_any;
        st_d.bus_oe    = boff_n_i;
        kind           = ISS_NONE;
        retire         = 1'b0;

        if (!boff_n_i) begin
            // abort: every issued cycle waits for a full re-issue
            st_d.icnt = '0;
        end else begin
            retire = done_i && (st_q.icnt != '0);
            if (!hold_i && repl_pend) begin
                kind = ISS_REPLAY;
            end else if (req_valid_i && ready) begin
                kind = ISS_NEW;
            end

            unique case (kind)
                ISS_REPLAY: begin
                    st_d.ads_n     = 1'b0;
                    st_d.ads_dup_n = 1'b0;
                    st_d.addr      = iss_addr;
                    st_d.replay    = 1'b1;
                    st_d.rptr      = iss_idx;
                end
                ISS_NEW: begin
                    st_d.ads_n     = 1'b0;
                    st_d.ads_dup_n = 1'b0;
                    st_d.addr      = req_addr_i;
                    st_d.rptr      = tail_idx;
                end
                default: ;
            endcase

            st_d.cnt  = st_q.cnt + CNT_W'(kind == ISS_NEW) - CNT_W'(retire);
            st_d.icnt = st_q.icnt + CNT_W'(kind != ISS_NONE) - CNT_W'(retire);
            if (retire) begin
                st_d.head = st_q.head + IDX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.ads_n     <= 1'b1;
            st_q.ads_dup_n <= 1'b1;
            st_q.addr_oe   <= 1'b1;
            st_q.par_oe    <= 1'b1;
            st_q.bus_oe    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready_o  = ready;
    assign ads_n_o      = st_q.ads_n;
    assign ads_dup_n_o  = st_q.ads_dup_n;
    assign addr_o       = st_q.addr;
    assign addr_oe_o    = st_q.addr_oe;
    assign par_oe_o     = st_q.par_oe;
    assign bus_oe_o     = st_q.bus_oe;
    assign replay_o     = st_q.replay;
    assign replay_ptr_o = st_q.rptr;
    assign out_cnt_o    = st_q.cnt;
endmodule

// File: rtl/bhc_chk.sv
module bhc_chk #(
    parameter int ADDR_W = 32,
    parameter int DEPTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hold_i,
    input logic              boff_n_i,
    input logic              req_ready_o,
    input logic              ads_n_o,
    input logic              ads_dup_n_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              par_o,
    input logic              addr_oe_o,
    input logic              par_oe_o,
    input logic              bus_oe_o,
    input logic [CNT_W-1:0]  out_cnt_o
);
    a_r2_hold_floats_addr: assert property (@(posedge clk) disable iff (!rst_n)
        hold_i |=> (!addr_oe_o && !par_oe_o));

    a_r4_no_strobe_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i || !boff_n_i) |=> ads_n_o);

    a_r4_not_ready_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i || !boff_n_i) |-> !req_ready_o);

    a_r5_boff_floats_all: assert property (@(posedge clk) disable iff (!rst_n)
        !boff_n_i |=> (!bus_oe_o && !addr_oe_o && !par_oe_o));

    a_r7_dup_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ads_dup_n_o == ads_n_o);

    a_r8_even_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (^{addr_o, par_o}) == 1'b0);

    a_r10_cap: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt_o <= CNT_W'(DEPTH));

    a_r10_full_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (out_cnt_o == CNT_W'(DEPTH)) |-> !req_ready_o);
endmodule

bind bushold_ctl bhc_chk #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hold_i      (hold_i),
    .boff_n_i    (boff_n_i),
    .req_ready_o (req_ready_o),
    .ads_n_o     (ads_n_o),
    .ads_dup_n_o (ads_dup_n_o),
    .addr_o      (addr_o),
    .par_o       (par_o),
    .addr_oe_o   (addr_oe_o),
    .par_oe_o    (par_oe_o),
    .bus_oe_o    (bus_oe_o),
    .out_cnt_o   (out_cnt_o)
);

// File: tb/sim_bushold_ctl.sv
module sim_bushold_ctl;
    localparam int ADDR_W = 32;
    localparam int DEPTH  = 4;
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid_i = 1'b0;
    logic [ADDR_W-1:0] req_addr_i = '0;
    logic              req_ready_o;
    logic              hold_i = 1'b0;
    logic              boff_n_i = 1'b1;
    logic              done_i = 1'b0;
    logic              ads_n_o, ads_dup_n_o, par_o;
    logic [ADDR_W-1:0] addr_o;
    logic              addr_oe_o, par_oe_o, bus_oe_o, replay_o;
    logic [IDX_W-1:0]  replay_ptr_o;
    logic [CNT_W-1:0]  out_cnt_o;

    always #5 clk = ~clk;

    bushold_ctl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_addr_i(req_addr_i), .req_ready_o(req_ready_o),
        .hold_i(hold_i), .boff_n_i(boff_n_i), .done_i(done_i),
        .ads_n_o(ads_n_o), .ads_dup_n_o(ads_dup_n_o), .addr_o(addr_o), .par_o(par_o),
        .addr_oe_o(addr_oe_o), .par_oe_o(par_oe_o), .bus_oe_o(bus_oe_o),
        .replay_o(replay_o), .replay_ptr_o(replay_ptr_o), .out_cnt_o(out_cnt_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // reference model
    logic [ADDR_W-1:0] m_addr [DEPTH];
    int m_head = 0, m_cnt = 0, m_icnt = 0;
    logic e_ads = 1'b1, e_rep = 1'b0, e_aoe = 1'b1, e_boe = 1'b1;
    logic [ADDR_W-1:0] e_addr = '0;
    int e_rptr = 0;
    bit  last_acc = 1'b1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_ready(input bit h, input bit bn);
        return !(h || !bn) && (m_icnt == m_cnt) && (m_cnt < DEPTH);
    endfunction

    task automatic check_outputs();
        chk(ads_n_o == e_ads, "R8", "ads_n", ads_n_o, e_ads);
        chk(ads_dup_n_o == ads_n_o, "R7", "dup strobe", ads_dup_n_o, ads_n_o);
        chk(addr_oe_o == e_aoe, "R2", "addr_oe", addr_oe_o, e_aoe);
        chk(par_oe_o == e_aoe, "R2", "par_oe", par_oe_o, e_aoe);
        chk(bus_oe_o == e_boe, "R5", "bus_oe", bus_oe_o, e_boe);
        chk(out_cnt_o == CNT_W'(m_cnt), "R3", "out_cnt", out_cnt_o, m_cnt);
        chk(par_o == ^addr_o, "R8", "parity", par_o, ^addr_o);
        chk(replay_o == e_rep, "R6", "replay flag", replay_o, e_rep);
        if (!e_ads) begin
            chk(addr_o == e_addr, "R6", "strobe addr", addr_o, e_addr);
            chk(replay_ptr_o == IDX_W'(e_rptr), "R8", "slot", replay_ptr_o, e_rptr);
        end
    endtask

    // one clock: check last results, drive inputs, check ready, update model
    task automatic step(input bit h, input bit bn, input bit dn, input bit rv);
        bit er, hold_any, pend, ret;
        int slot;
        @(negedge clk);
        check_outputs();
        if (last_acc) req_addr_i = $urandom;
        hold_i = h; boff_n_i = bn; req_valid_i = rv;
        done_i = dn && (m_icnt > 0);
        #1;
        er = exp_ready(h, bn);
        chk(req_ready_o == er, (h || !bn) ? "R4" : (m_cnt == DEPTH ? "R10" : "R6"),
            "ready", req_ready_o, er);
        hold_any = h || !bn;
        pend = (m_icnt != m_cnt);
        e_aoe = !hold_any; e_boe = bn; e_ads = 1'b1; e_rep = 1'b0;
        last_acc = 1'b0;
        if (!bn) begin
            m_icnt = 0;
        end else begin
            ret = done_i && (m_icnt != 0);
            if (!h && pend) begin
                e_rptr = (m_head + m_icnt) % DEPTH;
                e_addr = m_addr[e_rptr];
                e_ads = 1'b0; e_rep = 1'b1;
                m_icnt++;
            end else if (rv && er) begin
                slot = (m_head + m_cnt) % DEPTH;
                m_addr[slot] = req_addr_i;
                e_addr = req_addr_i; e_rptr = slot; e_ads = 1'b0;
                m_cnt++; m_icnt++;
                last_acc = 1'b1;
            end
            if (ret) begin
                m_head = (m_head + 1) % DEPTH;
                m_cnt--; m_icnt--;
            end
        end
    endtask

    initial begin
        bit h, bn;
        process::self().srandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(ads_n_o == 1'b1, "R1", "ads_n at reset", ads_n_o, 1);
        chk(addr_oe_o && par_oe_o && bus_oe_o, "R1", "oe at reset",
            {addr_oe_o, par_oe_o, bus_oe_o}, 3'b111);
        chk(out_cnt_o == '0, "R1", "count at reset", out_cnt_o, 0);
        chk(req_ready_o == 1'b1, "R1", "ready at reset", req_ready_o, 1);
        rst_n = 1'b1;

        // directed: fill three cycles, then address hold with a completion (R2, R3)
        repeat (3) step(0, 1, 0, 1);
        step(1, 1, 0, 1);
        step(1, 1, 1, 1);
        step(1, 1, 0, 0);
        // fill to capacity (R10)
        repeat (4) step(0, 1, 0, 1);
        // both requests together (R9), done ignored under backoff (R5)
        step(1, 0, 1, 1);
        step(1, 0, 0, 1);
        step(0, 1, 0, 1);
        // replays in order (R6)
        repeat (6) step(0, 1, 0, 1);
        repeat (5) step(0, 1, 1, 0);

        // constrained random with sticky hold/backoff windows
        h = 0; bn = 1;
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 12) == 0) h = !h;
            if (bn ? (($urandom % 25) == 0) : (($urandom % 5) == 0)) bn = !bn;
            step(h, bn, ($urandom % 5) < 2, ($urandom % 10) < 7);
        end
        repeat (12) step(0, 1, 1, 0);
        @(negedge clk);
        check_outputs();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule